// File: doc/BRIEF.md
# Transport-layer test pattern generator

This block sits in front of the transport stage of a multi-converter serial-link transmitter. In normal operation it forwards the per-converter sample words unchanged. When test mode is active, it replaces each sample slot with a fixed 16-bit word. The receiving converter can then compare every slot against the value it expects, one slot at a time. Framing, lane mapping, scrambling and the physical layer are handled elsewhere.

The word for each slot comes from a short multiply-add hash. Its seed is built from the converter number and the sample number. All words depend only on the parameters, so they are constants and no arithmetic runs per cycle. The switch between test words and live data is taken only on a frame boundary, marked by a one-cycle strobe. The output is registered, giving one cycle of latency. The number of converters (default 4) and of samples per converter per frame (default 2) are parameters, each at most 256.

Top module: `tpg_top`

## Requirements
- R1: While `rst_n` is low, and after its release until the first clock edge that updates them, `sample_out` is all zeros and `pattern_active` is 0.
- R2: When `pattern_active` is 0 after a clock edge, `sample_out` equals the `sample_in` value sampled at that edge (one register of latency).
- R3: In test mode, slot (c, s) carries the low 16 bits of ((seed + 1) * 0x31415979 + 1), computed in 32-bit wrapping unsigned arithmetic. The seed is (c << 8) | s.
- R4: Slot (c, s) occupies bits [16*(c*S+s) +: 16] of the flat buses. Converter 0, sample 0 sits at the least significant end, and the sample index runs fastest.
- R5: At a clock edge with `frame_start` high, `pattern_active` takes the value of `test_en`. The output driven at that same edge already follows the new mode.
- R6: At a clock edge with `frame_start` low, `test_en` is ignored: `pattern_active` and the choice between test words and live data stay as they were.
- R7: While `pattern_active` is 1, `sample_out` stays constant whatever `sample_in` does.
- R8: The converter count M and sample count S are parameters, and the slot count, the bus widths and the words follow them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_en | input | 1 | Request for test mode, taken on a frame boundary |
| frame_start | input | 1 | One-cycle strobe marking the first cycle of a frame |
| sample_in | input | M*S*16 | Live sample words, slot (c, s) at bits [16*(c*S+s) +: 16] |
| sample_out | output | M*S*16 | Selected sample words, same packing |
| pattern_active | output | 1 | 1 while test words are being driven |

## Verification
The bench builds two instances:

- The default instance has 4 converters and 2 samples. It exercises mode switching, pass-through and the rule that `test_en` is ignored between frame strobes.
- A second instance has 3 converters and 5 samples. The larger sample count puts sample indices up to 4 into the low byte of the seed. The uneven shape also checks that the slot index c*S+s lands on the right bit range when M and S differ.

// File: rtl/tpg_pkg.sv
// Package: shared constants and the slot-word hash for the test pattern generator.
// Assumes converter and sample indices each fit in 8 bits.
package tpg_pkg;

    localparam int unsigned SAMPLE_W  = 16;
    localparam int unsigned IDX_W     = 8;
    localparam logic [31:0] HASH_MULT = 32'h3141_5979;

    // Computes the constant test word for converter conv, sample samp.
    function automatic logic [SAMPLE_W-1:0] slot_word(input int unsigned conv,
                                                      input int unsigned samp);
        logic [31:0] seed;
        logic [31:0] prod;
        seed = (32'(conv) << IDX_W) | 32'(samp);
        prod = (seed + 32'd1) * HASH_MULT + 32'd1;
        return prod[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/tpg_pattern_table.sv
// Module: tpg_pattern_table
// Produces the constant test word of every converter/sample slot, packed flat
// with slot index c*S+s. Pure constants: no logic is left after elaboration.
// Assumes M <= 256 and S <= 256.
module tpg_pattern_table #(
    parameter int unsigned M = 4,
    parameter int unsigned S = 2
) (
    output logic [M*S*tpg_pkg::SAMPLE_W-1:0] pattern
);
    import tpg_pkg::*;

    localparam int unsigned W = SAMPLE_W;

    // One constant word per slot, placed at its packed position.
    for (genvar c = 0; c < M; c++) begin : g_conv
        for (genvar s = 0; s < S; s++) begin : g_samp
            assign pattern[(c*S+s)*W +: W] = slot_word(c, s);
        end
    end

endmodule

// File: rtl/tpg_mode_ctrl.sv
// Module: tpg_mode_ctrl
// Holds the test/normal mode and changes it only on a frame strobe.
// mode_next is the mode that applies to data captured at the current edge.
// Assumes frame_start is a single-cycle strobe.
module tpg_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    input  logic frame_start,
    output logic mode_next,
    output logic mode_q
);

    // Picks the requested mode on a frame boundary, else keeps the held mode.
    always_comb begin
        mode_next = frame_start ? test_en : mode_q;
    end

    // Stores the active mode, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_next;
    end

endmodule

// File: rtl/tpg_lane_mux.sv
// Module: tpg_lane_mux
// Registered per-slot selector between the live sample and the test word.
// Assumes sel is already aligned to the frame boundary by the caller.
module tpg_lane_mux #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic [SLOTS*W-1:0] live,
    input  logic [SLOTS*W-1:0] test,
    output logic [SLOTS*W-1:0] dout
);

    // One output register per slot.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        // Captures the test word or the live sample for slot k.
        always_ff @(posedge clk) begin
            if (!rst_n)   dout[k*W +: W] <= '0;
            else if (sel) dout[k*W +: W] <= test[k*W +: W];
            else          dout[k*W +: W] <= live[k*W +: W];
        end
    end

endmodule

// File: rtl/tpg_top.sv
// Module: tpg_top
// Transport-layer test pattern generator. Forwards live samples, or drives a
// constant hashed word per converter/sample slot when test mode is active.
// The mode changes only on frame_start. The output has one cycle of latency.
// Assumes M and S are each between 1 and 256.
module tpg_top #(
    parameter int unsigned M = 4,
    parameter int unsigned S = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                test_en,
    input  logic                                frame_start,
    input  logic [M*S*tpg_pkg::SAMPLE_W-1:0]    sample_in,
    output logic [M*S*tpg_pkg::SAMPLE_W-1:0]    sample_out,
    output logic                                pattern_active
);
    import tpg_pkg::*;

    localparam int unsigned SLOTS = M * S;
    localparam int unsigned BUS_W = SLOTS * SAMPLE_W;

    logic [BUS_W-1:0] pattern_words;
    logic             mode_next;

    tpg_pattern_table #(.M(M), .S(S)) u_table (
        .pattern (pattern_words)
    );

    tpg_mode_ctrl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_en     (test_en),
        .frame_start (frame_start),
        .mode_next   (mode_next),
        .mode_q      (pattern_active)
    );

    tpg_lane_mux #(.SLOTS(SLOTS), .W(SAMPLE_W)) u_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (mode_next),
        .live  (sample_in),
        .test  (pattern_words),
        .dout  (sample_out)
    );

endmodule

// File: rtl/tpg_checker.sv
// Module: tpg_checker
// Temporal checks on the ports of tpg_top. Attached through bind below.
module tpg_checker #(
    parameter int unsigned M = 4,
    parameter int unsigned S = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             test_en,
    input logic                             frame_start,
    input logic [M*S*tpg_pkg::SAMPLE_W-1:0] sample_in,
    input logic [M*S*tpg_pkg::SAMPLE_W-1:0] sample_out,
    input logic                             pattern_active
);

    // R5: a frame strobe loads the requested mode.
    assert_mode_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pattern_active == $past(test_en)));

    // R6: without a strobe the mode holds.
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(pattern_active));

    // R7: the test words do not move while test mode continues.
    assert_pattern_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_active && $past(pattern_active) && $past(rst_n)) |-> $stable(sample_out));

    // R2: in normal mode the output is last cycle's input.
    assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pattern_active && $past(rst_n)) |-> (sample_out == $past(sample_in)));

endmodule

bind tpg_top tpg_checker #(.M(M), .S(S)) u_tpg_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .test_en        (test_en),
    .frame_start    (frame_start),
    .sample_in      (sample_in),
    .sample_out     (sample_out),
    .pattern_active (pattern_active)
);

// File: tb/tpg_top_test.sv
`timescale 1ns/1ps
module tpg_top_test;

    localparam int M  = 4;
    localparam int S  = 2;
    localparam int M2 = 3;
    localparam int S2 = 5;
    localparam int W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_en = 1'b0;
    logic frame_start = 1'b0;
    logic [M*S*W-1:0]   din = '0;
    logic [M*S*W-1:0]   dout;
    logic               active;
    logic [M2*S2*W-1:0] din2 = '0;
    logic [M2*S2*W-1:0] dout2;
    logic               active2;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tpg_top #(.M(M), .S(S)) uut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .frame_start(frame_start),
        .sample_in(din), .sample_out(dout), .pattern_active(active)
    );

    tpg_top #(.M(M2), .S(S2)) uut_alt (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .frame_start(frame_start),
        .sample_in(din2), .sample_out(dout2), .pattern_active(active2)
    );

    // Expected test word, straight from the requirement formula.
    function automatic logic [15:0] expect_word(input int c, input int s);
        logic [31:0] seed;
        logic [31:0] v;
        seed = (c * 256) + s;
        v = (seed + 32'd1) * 32'h3141_5979 + 32'd1;
        return v[15:0];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, let one rising edge pass, sample after it.
    task automatic step(input logic fs, input logic en, input logic [M*S*W-1:0] d);
        @(negedge clk);
        frame_start = fs;
        test_en     = en;
        din         = d;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 out", 64'(dout), 64'd0);
        check("R1 active", 64'(active), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_passthrough;
        logic [M*S*W-1:0] v;
        for (int k = 0; k < 3; k++) begin
            v = {M*S{16'h1111 * 16'(k + 1)}} ^ {{(M*S*W-32){1'b0}}, 32'hDEAD_BEEF};
            step(1'b0, 1'b0, v);
            check("R2 passthrough", dout[63:0], v[63:0]);
            check("R2 passthrough hi", dout[M*S*W-1 -: 64], v[M*S*W-1 -: 64]);
        end
    endtask

    task automatic t_ignored_between_frames;
        step(1'b0, 1'b1, {M*S{16'hA5A5}});
        check("R6 active unchanged", 64'(active), 64'd0);
        check("R6 data still live", 64'(dout[15:0]), 64'h0000_A5A5);
    endtask

    task automatic t_enter_pattern;
        step(1'b1, 1'b1, {M*S{16'h7777}});
        check("R5 active set", 64'(active), 64'd1);
        for (int c = 0; c < M; c++)
            for (int s = 0; s < S; s++)
                check("R3 R4 slot word", 64'(dout[(c*S+s)*W +: W]), 64'(expect_word(c, s)));
    endtask

    task automatic t_pattern_holds;
        logic [M*S*W-1:0] snap;
        snap = dout;
        step(1'b0, 1'b1, {M*S{16'h0F0F}});
        check("R7 stable word", dout[63:0], snap[63:0]);
        step(1'b0, 1'b0, {M*S{16'hF0F0}});
        check("R6 test_en drop ignored", 64'(active), 64'd1);
        check("R7 stable after drop", dout[M*S*W-1 -: 64], snap[M*S*W-1 -: 64]);
    endtask

    task automatic t_alt_shape;
        for (int c = 0; c < M2; c++)
            for (int s = 0; s < S2; s++)
                check("R8 R4 alt slot word", 64'(dout2[(c*S2+s)*W +: W]), 64'(expect_word(c, s)));
    endtask

    task automatic t_leave_pattern;
        logic [M*S*W-1:0] v;
        v = {M*S{16'h3C5A}};
        step(1'b1, 1'b0, v);
        check("R5 active cleared", 64'(active), 64'd0);
        check("R5 live at frame edge", dout[63:0], v[63:0]);
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_passthrough();
        t_ignored_between_frames();
        t_enter_pattern();
        t_alt_shape();
        t_pattern_holds();
        t_leave_pattern();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule